// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible control point for a bank of up to twelve DMA channel engines. Through seven 32-bit word offsets it lets a host choose each channel's transfer mode and direction and enable its interrupt. It also lets the host observe, and acknowledge, completion and error events together with each engine's live activity state. The per-channel controls are fanned out to the engines as plain signals. Each engine returns a one-cycle done pulse, a one-cycle error pulse and a 2-bit state code.

Channels are split into a low group (0 to 7) and a high group (8 to 11). Each group has its own control word and status word, and the bit positions differ between the two groups. A mode code of 3 means "keep the current mode". Software can therefore rewrite one channel's field without disturbing its neighbours. It must still write the direction bits it wants. All event flags from all channels are gated by their enables and merged onto a single interrupt line.

The bus side is a simple write strobe with a byte address and write data, plus a combinational read data output. The reset input is asynchronous. It is released internally through a two-stage synchronizer.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset every mode, direction, enable and flag is zero, `irq` is low, no start pulse is issued, and reads of offsets 0x00, 0x08 and 0x0C return 0.
- R2: Channel c in 0..7 owns a 4-bit field at bit 4*c of offset 0x00. Bits [1:0] are the mode: 0 off, 1 scatter-gather, 2 one-shot. Bit 2 is the direction: 1 means memory-to-device, 0 means device-to-memory. A write takes effect on `ch_mode`/`ch_dir` in the next cycle and is read back in the same positions.
- R3: Channel c in 8..11 owns the same kind of field at bit 4*(c-8) of offset 0x0C.
- R4: Writing mode code 3 into a field leaves that channel's mode unchanged, while its direction bit is still updated.
- R5: A control-word write that puts mode 1 or 2 into a channel's field raises that channel's `ch_start` for exactly one cycle, the cycle after the write. Codes 0 and 3 give no pulse.
- R6: Offset 0x08 holds the interrupt enables: bit c for channels 0..7 and bit c+8 for channels 8..11. Every other bit of this offset reads 0.
- R7: A `ch_done` pulse sets the channel's event flag. The flag reads at bit c of offset 0x10 for channels 0..7, and at bit c-8 of offset 0x18 for channels 8..11.
- R8: A `ch_err` pulse sets the channel's error flag and also its event flag. The error flag reads at bit c+8 of offset 0x10 for channels 0..7, and at bit c of offset 0x18 for channels 8..11.
- R9: Each channel's 2-bit `ch_state` (0 idle, 1 descriptor fetch, 2 waiting, 3 moving data) reads live at bit 16+2*c of 0x10 for channels 0..7, and at bit 16+2*(c-8) of 0x18 for channels 8..11.
- R10: Writing 0x10 or 0x18 clears exactly the event and error flags whose bits are 1 in the written value, and leaves the others. A set pulse in the same cycle as a clear wins.
- R11: `irq` is high exactly when some channel has both its event flag and its interrupt enable set.
- R12: Offsets 0x04, 0x14, 0x1C and unaligned addresses read 0. Writes to them change nothing. Reserved field bits (bit 3 of each control nibble) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (5) | Byte address of the register |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data, combinational from `reg_addr` |
| ch_mode | output | 2*N_CH (24) | Mode per channel, 2 bits each |
| ch_dir | output | N_CH (12) | Direction per channel, 1 = memory-to-device |
| ch_start | output | N_CH (12) | One-cycle start pulse per channel |
| ch_done | input | N_CH (12) | Done pulse from each engine |
| ch_err | input | N_CH (12) | Error pulse from each engine |
| ch_state | input | 2*N_CH (24) | Activity state from each engine, 2 bits each |
| irq | output | 1 | Shared interrupt request |

## Verification
The control words are written with mixed patterns: different modes and directions in neighbouring nibbles, a set reserved bit, and all-keep codes mixed with real codes. These patterns separate correct field placement from shifted or merged fields, and show the keep code gating only the mode. Event and error pulses are driven on one low-group and one high-group channel at a time. This exposes the irregular flag positions of the two status words. Partial write-one-to-clear values and a clear that collides with a set pulse tell apart selective, blanket and ordering-dependent clearing. The interrupt is exercised with the flag set but disabled, then enabled, then cleared, and again on a high channel, so that the mask and the high-group enable position are both pinned down.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int MAX_CH = 12;
  localparam int LO_CH  = 8;

  localparam logic [4:0] OFS_CTL0 = 5'h00;
  localparam logic [4:0] OFS_CTL1 = 5'h04;
  localparam logic [4:0] OFS_CTL2 = 5'h08;
  localparam logic [4:0] OFS_CTL3 = 5'h0C;
  localparam logic [4:0] OFS_STS0 = 5'h10;
  localparam logic [4:0] OFS_STS1 = 5'h14;
  localparam logic [4:0] OFS_STS2 = 5'h18;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SG   = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_KEEP = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DESC = 2'd1,
    ST_WAIT = 2'd2,
    ST_XFER = 2'd3
  } state_e;

  function automatic bit in_hi(input int ch);
    return ch >= LO_CH;
  endfunction

  function automatic int ctl_lsb(input int ch);
    return in_hi(ch) ? 4 * (ch - LO_CH) : 4 * ch;
  endfunction

  function automatic int ie_bit(input int ch);
    return in_hi(ch) ? ch + 8 : ch;
  endfunction

  function automatic int int_bit(input int ch);
    return in_hi(ch) ? ch - LO_CH : ch;
  endfunction

  function automatic int err_bit(input int ch);
    return in_hi(ch) ? ch : ch + 8;
  endfunction

  function automatic int st_lsb(input int ch);
    return in_hi(ch) ? 16 + 2 * (ch - LO_CH) : 16 + 2 * ch;
  endfunction

endpackage

// File: rtl/dma_csr_chan_ctl.sv
module dma_csr_chan_ctl
  import dma_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [3:0] field,
  output logic [1:0] mode_o,
  output logic       dir_o,
  output logic       start_o
);

  logic [1:0] mode_q, mode_d;
  logic       dir_q, dir_d;
  logic       start_q, start_d;
  logic       cfg_en;
  logic       mode_en;

  assign cfg_en  = wr_hit;
  assign mode_en = wr_hit && (field[1:0] != MODE_KEEP);

  always_comb begin
    mode_d  = mode_q;
    dir_d   = dir_q;
    start_d = 1'b0;
    if (mode_en) mode_d = field[1:0];
    if (cfg_en)  dir_d  = field[2];
    if (cfg_en)  start_d = (field[1:0] == MODE_SG) || (field[1:0] == MODE_ONCE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      dir_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (cfg_en)  dir_q  <= dir_d;
      start_q <= start_d;
    end
  end

  assign mode_o  = mode_q;
  assign dir_o   = dir_q;
  assign start_o = start_q;

  // R4
  keep_code_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && field[1:0] == MODE_KEEP) |=> (mode_o == $past(mode_o)));

  // R5
  start_has_live_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (mode_o == MODE_SG || mode_o == MODE_ONCE) && !$past(start_o));

endmodule

// File: rtl/dma_csr_chan_flags.sv
module dma_csr_chan_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic err,
  input  logic clr_int,
  input  logic clr_err,
  output logic int_o,
  output logic err_o
);

  logic int_q, int_d;
  logic err_q, err_d;
  logic int_en, err_en;

  assign int_en = done || err || clr_int;
  assign err_en = err || clr_err;

  always_comb begin
    int_d = int_q;
    err_d = err_q;
    if (done || err) int_d = 1'b1;
    else if (clr_int) int_d = 1'b0;
    if (err) err_d = 1'b1;
    else if (clr_err) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (int_en) int_q <= int_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign int_o = int_q;
  assign err_o = err_q;

  // R7
  done_sets_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> int_o);

  // R8
  err_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err_o && int_o));

endmodule

// File: rtl/dma_csr_rdmux.sv
module dma_csr_rdmux
  import dma_csr_pkg::*;
#(
  parameter int N_CH = 12,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic [AW-1:0]     addr,
  input  logic [2*N_CH-1:0] mode,
  input  logic [N_CH-1:0]   dir,
  input  logic [N_CH-1:0]   ie,
  input  logic [N_CH-1:0]   intf,
  input  logic [N_CH-1:0]   errf,
  input  logic [2*N_CH-1:0] state,
  output logic [DW-1:0]     rdata
);

  logic [DW-1:0] w_ctl0, w_ctl2, w_ctl3, w_sts0, w_sts2;

  always_comb begin
    w_ctl0 = '0;
    w_ctl2 = '0;
    w_ctl3 = '0;
    w_sts0 = '0;
    w_sts2 = '0;
    for (int c = 0; c < N_CH; c++) begin
      w_ctl2[ie_bit(c)] = ie[c];
      if (in_hi(c)) begin
        w_ctl3[ctl_lsb(c) +: 2] = mode[2*c +: 2];
        w_ctl3[ctl_lsb(c) + 2]  = dir[c];
        w_sts2[int_bit(c)]      = intf[c];
        w_sts2[err_bit(c)]      = errf[c];
        w_sts2[st_lsb(c) +: 2]  = state[2*c +: 2];
      end else begin
        w_ctl0[ctl_lsb(c) +: 2] = mode[2*c +: 2];
        w_ctl0[ctl_lsb(c) + 2]  = dir[c];
        w_sts0[int_bit(c)]      = intf[c];
        w_sts0[err_bit(c)]      = errf[c];
        w_sts0[st_lsb(c) +: 2]  = state[2*c +: 2];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_CTL0)) rdata = w_ctl0;
    if (addr == AW'(OFS_CTL2)) rdata = w_ctl2;
    if (addr == AW'(OFS_CTL3)) rdata = w_ctl3;
    if (addr == AW'(OFS_STS0)) rdata = w_sts0;
    if (addr == AW'(OFS_STS2)) rdata = w_sts2;
  end

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int N_CH = 12,
  parameter int AW   = 5,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [2*N_CH-1:0] ch_mode,
  output logic [N_CH-1:0]   ch_dir,
  output logic [N_CH-1:0]   ch_start,
  input  logic [N_CH-1:0]   ch_done,
  input  logic [N_CH-1:0]   ch_err,
  input  logic [2*N_CH-1:0] ch_state,
  output logic              irq
);

  localparam int FW = 4;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic wr_ctl0, wr_ctl2, wr_ctl3, wr_sts0, wr_sts2;

  assign wr_ctl0 = reg_we && (reg_addr == AW'(OFS_CTL0));
  assign wr_ctl2 = reg_we && (reg_addr == AW'(OFS_CTL2));
  assign wr_ctl3 = reg_we && (reg_addr == AW'(OFS_CTL3));
  assign wr_sts0 = reg_we && (reg_addr == AW'(OFS_STS0));
  assign wr_sts2 = reg_we && (reg_addr == AW'(OFS_STS2));

  logic [N_CH-1:0] ie_q, ie_d;
  logic [N_CH-1:0] int_flag, err_flag;

  always_comb begin
    ie_d = ie_q;
    for (int c = 0; c < N_CH; c++) ie_d[c] = reg_wdata[ie_bit(c)];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ie_q <= '0;
    else if (wr_ctl2) ie_q <= ie_d;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam bit HI = in_hi(g);
    logic          wr_hit;
    logic [FW-1:0] field;
    logic          sts_wr;

    assign wr_hit = HI ? wr_ctl3 : wr_ctl0;
    assign field  = reg_wdata[ctl_lsb(g) +: FW];
    assign sts_wr = HI ? wr_sts2 : wr_sts0;

    dma_csr_chan_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_hit  (wr_hit),
      .field   (field),
      .mode_o  (ch_mode[2*g +: 2]),
      .dir_o   (ch_dir[g]),
      .start_o (ch_start[g])
    );

    dma_csr_chan_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .done    (ch_done[g]),
      .err     (ch_err[g]),
      .clr_int (sts_wr && reg_wdata[int_bit(g)]),
      .clr_err (sts_wr && reg_wdata[err_bit(g)]),
      .int_o   (int_flag[g]),
      .err_o   (err_flag[g])
    );
  end

  dma_csr_rdmux #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_rdmux (
    .addr  (reg_addr),
    .mode  (ch_mode),
    .dir   (ch_dir),
    .ie    (ie_q),
    .intf  (int_flag),
    .errf  (err_flag),
    .state (ch_state),
    .rdata (reg_rdata)
  );

  assign irq = |(int_flag & ie_q);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  // R11
  enabled_done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (((ch_done & ie_q) != '0) && !wr_ctl2) |=> irq);

  // R11
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ie_q == '0) |-> !irq);

endmodule

// File: tb/dma_chan_csr_test.sv
`timescale 1ns/1ps
module dma_chan_csr_test;

  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [4:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [2*N-1:0] ch_mode;
  logic [N-1:0]  ch_dir;
  logic [N-1:0]  ch_start;
  logic [N-1:0]  ch_done;
  logic [N-1:0]  ch_err;
  logic [2*N-1:0] ch_state;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_chan_csr uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_mode(ch_mode),
    .ch_dir(ch_dir), .ch_start(ch_start), .ch_done(ch_done), .ch_err(ch_err),
    .ch_state(ch_state), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] dn, input logic [N-1:0] er);
    @(negedge clk);
    ch_done = dn; ch_err = er;
    @(posedge clk);
    @(negedge clk);
    ch_done = '0; ch_err = '0;
  endtask

  // state pattern: channel c reports c mod 4; positions per R9
  function automatic logic [31:0] st_exp(input bit hi);
    logic [31:0] r = '0;
    for (int c = 0; c < N; c++) begin
      if (!hi && c < 8)  r[16 + 2*c +: 2]     = 2'(c % 4);
      if (hi  && c >= 8) r[16 + 2*(c-8) +: 2] = 2'(c % 4);
    end
    return r;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", "irq", {31'd0, irq}, 0);
    chk("R1", "modes", {8'd0, ch_mode}, 0);
    chk("R1", "starts", {20'd0, ch_start}, 0);
    rd(5'h00, d); chk("R1", "ctl0", d, 0);
    rd(5'h08, d); chk("R1", "ctl2", d, 0);
    rd(5'h0C, d); chk("R1", "ctl3", d, 0);
    rd(5'h10, d); chk("R1", "sts0", d, 0);
  endtask

  task automatic t_ctl_lo;
    logic [31:0] d;
    // ch0 SG+m2d, ch1 one-shot d2m, ch2 reserved bit only, ch7 one-shot m2d
    wr(5'h00, 32'h6000_0825);
    chk("R5", "start pulse low group", {20'd0, ch_start}, 32'h083);
    @(negedge clk);
    chk("R5", "start gone next cycle", {20'd0, ch_start}, 0);
    chk("R2", "ch0 mode", {30'd0, ch_mode[1:0]}, 1);
    chk("R2", "ch0 dir", {31'd0, ch_dir[0]}, 1);
    chk("R2", "ch1 mode", {30'd0, ch_mode[3:2]}, 2);
    chk("R2", "ch7 mode/dir", {29'd0, ch_dir[7], ch_mode[15:14]}, 3'b110);
    rd(5'h00, d); chk("R12", "ctl0 readback reserved dropped", d, 32'h6000_0025);
  endtask

  task automatic t_ctl_hi;
    logic [31:0] d;
    wr(5'h0C, 32'h0000_1006);
    chk("R5", "start pulse high group", {20'd0, ch_start}, 32'h900);
    chk("R3", "ch8 mode/dir", {29'd0, ch_dir[8], ch_mode[17:16]}, 3'b110);
    chk("R3", "ch11 mode/dir", {29'd0, ch_dir[11], ch_mode[23:22]}, 3'b001);
    rd(5'h0C, d); chk("R3", "ctl3 readback", d, 32'h0000_1006);
    rd(5'h00, d); chk("R3", "ctl0 untouched", d, 32'h6000_0025);
  endtask

  task automatic t_keep;
    logic [31:0] d;
    wr(5'h00, 32'h7333_3343);
    chk("R5", "no start for keep/off codes", {20'd0, ch_start}, 0);
    rd(5'h00, d); chk("R4", "keep code holds mode, dir updates", d, 32'h6000_0041);
  endtask

  task automatic t_ie;
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); chk("R6", "enable positions", d, 32'h000F_00FF);
    wr(5'h08, 32'h0000_0000);
    rd(5'h08, d); chk("R6", "enables cleared", d, 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    for (int c = 0; c < N; c++) ch_state[2*c +: 2] = 2'(c % 4);
    rd(5'h10, d); chk("R9", "sts0 states", d, st_exp(1'b0));
    rd(5'h18, d); chk("R9", "sts2 states", d, st_exp(1'b1));
    pulse(12'h404, 12'h220);
    rd(5'h10, d); chk("R8", "sts0 flags", d, 32'h0000_2024 | st_exp(1'b0));
    rd(5'h18, d); chk("R7", "sts2 flags", d, 32'h0000_0206 | st_exp(1'b1));
    wr(5'h10, 32'h0000_0004);
    rd(5'h10, d); chk("R10", "partial clear sts0", d, 32'h0000_2020 | st_exp(1'b0));
    wr(5'h18, 32'h0000_0200);
    rd(5'h18, d); chk("R10", "error-only clear sts2", d, 32'h0000_0006 | st_exp(1'b1));
    // set and clear collide on ch0
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h0000_0001; ch_done = 12'h001;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; ch_done = '0;
    rd(5'h10, d); chk("R10", "set wins over clear", d, 32'h0000_2021 | st_exp(1'b0));
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h10, d); chk("R10", "sts0 all cleared", d, st_exp(1'b0));
    rd(5'h18, d); chk("R10", "sts2 all cleared", d, st_exp(1'b1));
  endtask

  task automatic t_irq;
    pulse(12'h008, 12'h000);
    chk("R11", "flag without enable", {31'd0, irq}, 0);
    wr(5'h08, 32'h0000_0008);
    chk("R11", "enable raises irq", {31'd0, irq}, 1);
    wr(5'h10, 32'h0000_0008);
    chk("R11", "clear drops irq", {31'd0, irq}, 0);
    wr(5'h08, 32'h0008_0000);
    pulse(12'h800, 12'h000);
    chk("R11", "high channel enable bit", {31'd0, irq}, 1);
    wr(5'h18, 32'h0000_0008);
    chk("R11", "high channel clear", {31'd0, irq}, 0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h04, d); chk("R12", "offset 0x04", d, 0);
    rd(5'h14, d); chk("R12", "offset 0x14", d, 0);
    rd(5'h1C, d); chk("R12", "offset 0x1C", d, 0);
    rd(5'h02, d); chk("R12", "unaligned", d, 0);
    rd(5'h00, d); chk("R12", "ctl0 unaffected", d, 32'h6000_0041);
    rd(5'h08, d); chk("R12", "ctl2 unaffected", d, 32'h0008_0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ch_done = '0; ch_err = '0; ch_state = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_ctl_lo;
    t_ctl_hi;
    t_keep;
    t_ie;
    t_status;
    t_irq;
    t_reserved;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule